// File: doc/BRIEF.md
# Interleaved Radix-32 Modular Multiplier

This block forms two modular products, x·b mod m and y·b mod m, in one pass. It works through the multipliers one radix-32 digit at a time, most significant digit first. Each step scales the running remainder by 32, adds a digit multiple of the shared multiplicand, and adds a multiple of a preloaded negative modulus. The partial results stay in carry-save form throughout. The datapath has two stages: a digit stage and a remainder stage. Both stages are shared by the X and Y streams, which take turns on every clock. As a result, each stage always works on one stream while the other stage works on the other.

Operands are pre-scaled before a run. The modulus port carries -1024·m. The multiplier ports carry 1024·x and 1024·y. Each finished result equals 1024 times a residue in [0, 2m[, so a result can be loaded straight back as the multiplier of a later run. A second mode reduces a residue in [0, 2m[ against m. It runs two forced digit steps and produces 1024·(b - m), whose sign shows whether b lies below m. The quotient digit for each step comes from a truncated sum of the remainder's carry-save halves, compared against a ladder of multiples of 2m.

Top module: `dual_modmul`

## Requirements
- R1: After reset, busy_o and done_o are 0 and all four result ports are 0.
- R2: In multiply mode, the operand encodings are as follows: m_neg_i holds -1024·m as a two's complement number, x_i holds 1024·x, and b < 2m, x < 2m, m ≥ 1. The X result is formed as V = (res_x_sum_o + res_x_carry_o) mod 2^RW, read as signed. V is a multiple of 1024, V/1024 lies in [0, 2m[, and V/1024 ≡ x·b (mod m).
- R3: The Y result, resolved the same way from res_y_sum_o and res_y_carry_o, depends only on y_i (holding 1024·y, y < 2m), b_i and m_neg_i. It satisfies V/1024 ≡ y·b (mod m) with V/1024 in [0, 2m[, even when x ≠ y.
- R4: In multiply mode, done_o is a single-cycle pulse. It rises 2·ND+1 clock edges after the edge that samples start_i, where ND = ceil((W+11)/5). busy_o is 1 from the edge after start until the edge that raises done_o, where it falls.
- R5: When reduce_i is 1 at start, both resolved results equal 1024·(b - m) in RW-bit two's complement. Bit RW-1 of each is set exactly when b < m.
- R6: In reduce mode, done_o rises 5 clock edges after the edge that samples start_i.
- R7: A start_i pulse while busy_o is 1 is ignored. The results and the done timing are those of the run already in progress.
- R8: While busy_o is 0, all four result ports hold their values.
- R9: Take the low AW bits of a resolved result of the form 1024·r and drive them on x_i or y_i. The next multiply run then yields a residue congruent to r·b (mod m).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a run when idle |
| reduce_i | input | 1 | Selects range-reduction mode, sampled with start |
| m_neg_i | input | RW | -1024·m, two's complement, stable during a run |
| b_i | input | W+1 | Multiplicand, or the residue to reduce |
| x_i | input | AW | 1024·x, sampled at start |
| y_i | input | AW | 1024·y, sampled at start |
| res_x_sum_o | output | RW | X result, sum half |
| res_x_carry_o | output | RW | X result, carry half |
| res_y_sum_o | output | RW | Y result, sum half |
| res_y_carry_o | output | RW | Y result, carry half |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when both results are final |

## Verification
Both results are complete when done_o pulses. In multiply mode that is 2·ND+1 = 13 edges after the start edge at the default width. In reduce mode it is 5 edges after the start edge. The Y result is written one edge earlier, but the bench reads it only at the done cycle. The bench counts edges from the start edge and samples on the falling edge. It checks that done_o is still low one cycle before the due edge, high on it, and low again one cycle later. Only then does it resolve the carry-save pairs and compare them against residues computed in the bench.

// File: rtl/dual_modmul_pkg.sv
package dual_modmul_pkg;
  localparam int unsigned DIG_W    = 5;   // radix-32 digit
  localparam int unsigned SCL_W    = 10;  // operand pre-scale 2^10
  localparam int unsigned EST_DROP = 4;   // low bits dropped in quotient estimate
  localparam int unsigned Q_MAX    = 66;  // quotient digit bound
  localparam int unsigned Q_W      = 7;
  localparam int unsigned A_W      = 6;   // digit width incl. forced value 32

  // digits of 1024*x for x < 2^(w+1)
  function automatic int unsigned digits_for(int unsigned w);
    return (w + 1 + SCL_W + DIG_W - 1) / DIG_W;
  endfunction
endpackage

// File: rtl/csa42_add.sv
module csa42_add #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [N-1:0] c_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] sum_o,
  output logic [N-1:0] carry_o
);
  logic [N-1:0] s1, k1;

  assign s1      = a_i ^ b_i ^ c_i;
  assign k1      = ((a_i & b_i) | (a_i & c_i) | (b_i & c_i)) << 1;
  assign sum_o   = s1 ^ k1 ^ d_i;
  assign carry_o = ((s1 & k1) | (s1 & d_i) | (k1 & d_i)) << 1;
endmodule

// File: rtl/bmul_gen.sv
module bmul_gen import dual_modmul_pkg::*; #(
  parameter int unsigned BW = 17,
  parameter int unsigned RW = 34
) (
  input  logic [A_W-1:0] a_i,
  input  logic [BW-1:0]  b_i,
  output logic [RW-1:0]  p_o
);
  assign p_o = RW'(a_i) * RW'(b_i);
endmodule

// File: rtl/qmul_gen.sv
module qmul_gen import dual_modmul_pkg::*; #(
  parameter int unsigned RW = 34
) (
  input  logic [RW-1:0]  r_s_i,
  input  logic [RW-1:0]  r_c_i,
  input  logic [RW-1:0]  m_neg_i,
  input  logic           force_i,
  input  logic [Q_W-1:0] q_force_i,
  output logic [RW-1:0]  qm_o
);
  localparam int unsigned EW = RW - EST_DROP;

  logic [EW-1:0]    est, m2;
  logic [RW-1:0]    m_pos;
  logic [Q_MAX-1:0] hit;
  logic [Q_W-1:0]   q_nat, q;
  logic             unused_lo;

  // truncated carry-save estimate, floor(R/16) or one less
  assign est       = r_s_i[RW-1:EST_DROP] + r_c_i[RW-1:EST_DROP];
  assign unused_lo = ^{r_s_i[EST_DROP-1:0], r_c_i[EST_DROP-1:0]};
  assign m_pos     = -m_neg_i;
  assign m2        = EW'(m_pos >> (SCL_W - 1));

  for (genvar k = 0; k < Q_MAX; k++) begin : g_ladder
    assign hit[k] = (est >= EW'(k + 1) * m2);
  end

  always_comb begin
    q_nat = '0;
    for (int k = 0; k < Q_MAX; k++) q_nat += Q_W'(hit[k]);
    if (est[EW-1]) q_nat = '0;  // wrapped estimate of a tiny remainder
  end

  assign q    = force_i ? q_force_i : q_nat;
  assign qm_o = RW'(q) * m_neg_i;
endmodule

// File: rtl/dual_modmul.sv
module dual_modmul import dual_modmul_pkg::*; #(
  parameter  int unsigned W  = 16,
  localparam int unsigned ND = digits_for(W),
  localparam int unsigned AW = ND * DIG_W,
  localparam int unsigned RW = W + 18,
  localparam int unsigned BW = W + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          reduce_i,
  input  logic [RW-1:0] m_neg_i,
  input  logic [BW-1:0] b_i,
  input  logic [AW-1:0] x_i,
  input  logic [AW-1:0] y_i,
  output logic [RW-1:0] res_x_sum_o,
  output logic [RW-1:0] res_x_carry_o,
  output logic [RW-1:0] res_y_sum_o,
  output logic [RW-1:0] res_y_carry_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int unsigned CW = $clog2(2 * ND + 2);

  logic          busy_q, red_q, done_q;
  logic [CW-1:0] cnt_q, last_k, step;
  logic [AW-1:0] xs_q, ys_q;
  logic [RW-1:0] t_s_q, t_c_q, qm_q, r_s_q, r_c_q;
  logic [RW-1:0] t_s_d, t_c_d, qm_d, r_s_d, r_c_d, ab;
  logic [RW-1:0] rx_s_q, rx_c_q, ry_s_q, ry_c_q;
  logic [DIG_W-1:0] a_nat;
  logic [A_W-1:0]   a_dig;
  logic [Q_W-1:0]   q_force;
  logic             src_x, stage1_on;

  assign last_k    = red_q ? CW'(4) : CW'(2 * ND);
  assign stage1_on = cnt_q < last_k;
  assign src_x     = cnt_q[0];  // even: Y stream, odd: X stream
  assign step      = cnt_q >> 1;
  assign a_nat     = src_x ? xs_q[AW-1 -: DIG_W] : ys_q[AW-1 -: DIG_W];

  // reduce: step 0 a=32 q=0, step 1 a=0 q=1
  assign a_dig   = red_q ? ((step == CW'(0)) ? A_W'(32) : A_W'(0)) : {1'b0, a_nat};
  assign q_force = (red_q && step == CW'(1)) ? Q_W'(1) : Q_W'(0);

  bmul_gen #(.BW(BW), .RW(RW)) u_bmul (
    .a_i(a_dig), .b_i(b_i), .p_o(ab)
  );

  csa42_add #(.N(RW)) u_tadd (
    .a_i(r_s_q << DIG_W), .b_i(r_c_q << DIG_W), .c_i(ab), .d_i('0),
    .sum_o(t_s_d), .carry_o(t_c_d)
  );

  qmul_gen #(.RW(RW)) u_qmul (
    .r_s_i(r_s_q), .r_c_i(r_c_q), .m_neg_i(m_neg_i),
    .force_i(red_q), .q_force_i(q_force), .qm_o(qm_d)
  );

  csa42_add #(.N(RW)) u_radd (
    .a_i(t_s_q), .b_i(t_c_q), .c_i(qm_q), .d_i('0),
    .sum_o(r_s_d), .carry_o(r_c_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; red_q <= 1'b0; done_q <= 1'b0; cnt_q <= '0;
      xs_q <= '0; ys_q <= '0;
      t_s_q <= '0; t_c_q <= '0; qm_q <= '0; r_s_q <= '0; r_c_q <= '0;
      rx_s_q <= '0; rx_c_q <= '0; ry_s_q <= '0; ry_c_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1; red_q <= reduce_i; cnt_q <= '0;
          xs_q <= x_i; ys_q <= y_i;
          t_s_q <= '0; t_c_q <= '0; qm_q <= '0; r_s_q <= '0; r_c_q <= '0;
        end
      end else begin
        cnt_q <= cnt_q + CW'(1);
        r_s_q <= r_s_d;
        r_c_q <= r_c_d;
        if (stage1_on) begin
          t_s_q <= t_s_d; t_c_q <= t_c_d; qm_q <= qm_d;
          if (src_x) xs_q <= xs_q << DIG_W;
          else       ys_q <= ys_q << DIG_W;
        end
        if (cnt_q == last_k - CW'(1)) begin
          ry_s_q <= r_s_d; ry_c_q <= r_c_d;
        end
        if (cnt_q == last_k) begin
          rx_s_q <= r_s_d; rx_c_q <= r_c_d;
          done_q <= 1'b1; busy_q <= 1'b0;
        end
      end
    end
  end

  assign res_x_sum_o   = rx_s_q;
  assign res_x_carry_o = rx_c_q;
  assign res_y_sum_o   = ry_s_q;
  assign res_y_carry_o = ry_c_q;
  assign busy_o        = busy_q;
  assign done_o        = done_q;
endmodule

// File: rtl/dual_modmul_chk.sv
module dual_modmul_chk #(
  parameter int unsigned RW = 34
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [RW-1:0] res_x_sum_o,
  input logic [RW-1:0] res_x_carry_o,
  input logic [RW-1:0] res_y_sum_o,
  input logic [RW-1:0] res_y_carry_o
);
  a_r4_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r4_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r4_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  a_r7_busy_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r8_results_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> ($stable(res_x_sum_o) && $stable(res_x_carry_o) &&
                 $stable(res_y_sum_o) && $stable(res_y_carry_o)));
endmodule

bind dual_modmul dual_modmul_chk #(.RW(RW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .res_x_sum_o(res_x_sum_o), .res_x_carry_o(res_x_carry_o),
  .res_y_sum_o(res_y_sum_o), .res_y_carry_o(res_y_carry_o)
);

// File: tb/dual_modmul_tb.sv
module dual_modmul_tb;
  import dual_modmul_pkg::*;
  localparam int unsigned W    = 16;
  localparam int unsigned ND   = digits_for(W);
  localparam int unsigned AW   = ND * DIG_W;
  localparam int unsigned RW   = W + 18;
  localparam int unsigned BW   = W + 1;
  localparam int          LAT  = 2 * ND + 1;
  localparam int          RLAT = 5;

  // m, x, y, b
  localparam longint VEC [8][4] = '{
    '{64'd1,     64'd1,      64'd0,      64'd1},
    '{64'd65535, 64'd65535,  64'd131069, 64'd131069},
    '{64'd12345, 64'd777,    64'd24689,  64'd3000},
    '{64'd40000, 64'd0,      64'd79999,  64'd79999},
    '{64'd3,     64'd5,      64'd4,      64'd5},
    '{64'd65521, 64'd100000, 64'd65520,  64'd12},
    '{64'd32768, 64'd65535,  64'd32768,  64'd32767},
    '{64'd255,   64'd509,    64'd256,    64'd300}
  };

  logic          clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, reduce_i = 1'b0;
  logic [RW-1:0] m_neg_i = '0;
  logic [BW-1:0] b_i = '0;
  logic [AW-1:0] x_i = '0, y_i = '0;
  logic [RW-1:0] res_x_sum_o, res_x_carry_o, res_y_sum_o, res_y_carry_o;
  logic          busy_o, done_o;

  int     n_chk = 0, n_err = 0;
  longint got_x, got_y;
  logic [RW-1:0] raw_xs, raw_xc, raw_ys, raw_yc;

  dual_modmul #(.W(W)) u_dut (.*);

  always #5 clk_i = ~clk_i;

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: act running exp finished");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  function automatic longint resolve(input logic [RW-1:0] s, input logic [RW-1:0] c);
    logic [RW-1:0] v;
    v = s + c;
    return v[RW-1] ? longint'(v) - (longint'(1) << RW) : longint'(v);
  endfunction

  // V = 1024*r, r in [0,2m[, r == a*b mod m
  task automatic chk_mul(input string req, input longint m, input longint a,
                         input longint b, input longint v);
    longint r;
    r = v / 1024;
    chk(v >= 0 && v % 1024 == 0 && r < 2 * m && r % m == (a * b) % m,
        req, v, 1024 * ((a * b) % m));
  endtask

  task automatic run(input longint m, input longint xv, input longint yv,
                     input longint bv, input bit red, input int lat, input bit poke,
                     input logic [AW-1:0] x_raw, input logic [AW-1:0] y_raw,
                     input bit use_raw, input string req);
    @(negedge clk_i);
    m_neg_i  = RW'(-(m * 1024));
    b_i      = BW'(bv);
    x_i      = use_raw ? x_raw : AW'(xv * 1024);
    y_i      = use_raw ? y_raw : AW'(yv * 1024);
    reduce_i = red;
    start_i  = 1'b1;
    @(posedge clk_i);
    #1 start_i = 1'b0;
    for (int c = 1; c <= lat; c++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (poke && c == 3) begin start_i = 1'b1; reduce_i = ~red; end
      else begin start_i = 1'b0; reduce_i = red; end
      if (c == lat - 1) chk(!done_o && busy_o, {req, " done early"}, longint'(done_o), 0);
      if (c == lat)     chk(done_o && !busy_o, {req, " done due"}, longint'(done_o), 1);
    end
    raw_xs = res_x_sum_o; raw_xc = res_x_carry_o;
    raw_ys = res_y_sum_o; raw_yc = res_y_carry_o;
    got_x  = resolve(raw_xs, raw_xc);
    got_y  = resolve(raw_ys, raw_yc);
    @(negedge clk_i);
    chk(!done_o, "R4 done single pulse", longint'(done_o), 0);
    repeat (2) @(negedge clk_i);
    chk(res_x_sum_o == raw_xs && res_x_carry_o == raw_xc &&
        res_y_sum_o == raw_ys && res_y_carry_o == raw_yc,
        "R8 results held", resolve(res_x_sum_o, res_x_carry_o), got_x);
  endtask

  initial begin
    logic [AW-1:0] fb;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o, "R1 reset flags", longint'({busy_o, done_o}), 0);
    chk(res_x_sum_o == 0 && res_x_carry_o == 0 && res_y_sum_o == 0 && res_y_carry_o == 0,
        "R1 reset results", resolve(res_x_sum_o, res_x_carry_o), 0);
    rst_ni = 1'b1;

    for (int i = 0; i < 8; i++) begin
      run(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 1'b0, LAT, 1'b0, '0, '0, 1'b0, "R4");
      chk_mul("R2 X product", VEC[i][0], VEC[i][1], VEC[i][3], got_x);
      chk_mul("R3 Y product", VEC[i][0], VEC[i][2], VEC[i][3], got_y);
    end

    // reduce: m, b
    begin
      longint rm [5] = '{64'd1000, 64'd1000, 64'd1000, 64'd1000, 64'd65535};
      longint rb [5] = '{64'd0,    64'd999,  64'd1000, 64'd1999, 64'd65534};
      for (int i = 0; i < 5; i++) begin
        run(rm[i], 0, 0, rb[i], 1'b1, RLAT, 1'b0, '0, '0, 1'b0, "R6 reduce");
        chk(got_x == 1024 * (rb[i] - rm[i]), "R5 reduce X", got_x, 1024 * (rb[i] - rm[i]));
        chk(got_y == 1024 * (rb[i] - rm[i]), "R5 reduce Y", got_y, 1024 * (rb[i] - rm[i]));
        chk(((raw_xs + raw_xc) >> (RW - 1)) == RW'(rb[i] < rm[i]), "R5 sign",
            longint'(got_x < 0), longint'(rb[i] < rm[i]));
      end
    end

    // start pulse mid-run, reduce_i flipped
    run(VEC[2][0], VEC[2][1], VEC[2][2], VEC[2][3], 1'b0, LAT, 1'b1, '0, '0, 1'b0, "R7");
    chk_mul("R7 X unaffected", VEC[2][0], VEC[2][1], VEC[2][3], got_x);
    chk_mul("R7 Y unaffected", VEC[2][0], VEC[2][2], VEC[2][3], got_y);

    // feed results back as multipliers
    run(VEC[5][0], VEC[5][1], VEC[5][2], VEC[5][3], 1'b0, LAT, 1'b0, '0, '0, 1'b0, "R9 first");
    begin
      longint rx, ry;
      rx = got_x / 1024;
      ry = got_y / 1024;
      fb = AW'(got_y);
      run(VEC[5][0], 0, 0, 64'd54321, 1'b0, LAT, 1'b0, AW'(got_x), fb, 1'b1, "R9 second");
      chk_mul("R9 X chained", VEC[5][0], rx, 64'd54321, got_x);
      chk_mul("R9 Y chained", VEC[5][0], ry, 64'd54321, got_y);
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule